// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the configuration and the status of a bank of interrupt sources and decides when each one is offered to the presentation side. Every source is fixed at build time as either a level source or a message source. Each source has a target server, a priority, and a saved priority. A priority of 0xFF masks the source. The block keeps separate status flags for the two kinds of source: asserted and sent for level sources, and rejected and masked-pending for message sources. Because of these flags, an interrupt that was masked or turned away is offered again later and is not lost.

Software-side commands arrive on a single command port. A command either writes the server and priority of a source, turns a source off (masks it and saves its priority), or turns it back on (restores the saved priority). The presentation side sends back reject and end-of-interrupt notices by global source number. It can also ask for a resend, which walks every source once, one source per clock, and pauses while the presentation side is not ready. Deliveries leave through one registered output slot with a valid/ready handshake. The slot carries the global number, the priority and the target server.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, dlv_valid, cmd_ack and resend_busy are 0. Every source has priority and saved priority 0xFF with all status flags clear, and each source keeps its build-time type.
- R2: A message source fires when its src_line bit is 1 during a clock. If its priority is not 0xFF, one delivery follows with dlv_num = SRC_BASE + index, its priority and its server. With an idle slot the delivery appears two clocks after the firing cycle.
- R3: A message source that fires while masked is not delivered and is marked masked-pending. A later set or on command that leaves it unmasked delivers it exactly once.
- R4: A change on a level source's line updates its asserted flag and runs the level check. The check delivers the source only if it is unmasked, asserted and not yet sent, and it marks the source sent. A line that stays high causes no further delivery.
- R5: A reject naming a source clears its sent flag and sets its rejected flag, and causes no immediate delivery. On the next resend, a rejected message source is delivered once if unmasked and its flag is cleared. A level source is delivered again if it is still asserted.
- R6: An end-of-interrupt clears the sent flag of a level source and delivers nothing by itself. For a message source it has no effect.
- R7: cmd_op 1 (off) sets the priority to 0xFF and copies the old priority into the saved priority. cmd_op 2 (on) copies the saved priority back into the priority. Neither changes the server.
- R8: cmd_op 0 (set) writes the server, and writes cmd_prio into both the priority and the saved priority. After that, a level source runs the level check.
- R9: A command is refused in any of these cases: its number is outside SRC_BASE to SRC_BASE+NUM_SRC-1, cmd_op is 3, or a set command has cmd_prio above 0xFF. A refused command changes no state. One clock after any command, cmd_ack is 1 and cmd_err shows whether the command was refused.
- R10: While dlv_valid is 1 and dlv_ready is 0, the output fields hold steady. When several sources wait at once, the lowest index is delivered first.
- R11: A resend visits one source per clock in which dlv_ready is 1 and stands still while dlv_ready is 0. resend_busy stays high for exactly NUM_SRC ready clocks.
- R12: Reject and end-of-interrupt notices whose number is outside the source range are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Interrupt lines: level for level sources, firing pulse for message sources |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set, 1 off, 2 on, 3 invalid |
| cmd_num | input | NUM_W | Global source number of the command |
| cmd_server | input | SRV_W | Target server for a set command |
| cmd_prio | input | 9 | Priority for a set command; values above 0xFF are refused |
| cmd_ack | output | 1 | Command completed (one clock after cmd_valid) |
| cmd_err | output | 1 | Command was refused |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend walk over all sources |
| resend_busy | output | 1 | Resend walk in progress |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_num | output | NUM_W | Global source number of the delivery |
| dlv_prio | output | 8 | Priority of the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_ready | input | 1 | Presentation side accepts the delivery |

## Verification
The embedded assertions check the following rules on every clock:
- the output slot holds steady under back-pressure;
- delivered numbers stay in range;
- the resend walk stands still when dlv_ready is low;
- an invalid opcode always raises cmd_err;
- a masked firing always leaves a masked-pending mark;
- a sent level source stays sent until a reject or an end-of-interrupt;
- a reject leaves the source unsent and rejected.

The other behaviours involve ordering across several events, and only the bench scenarios show them:
- a masked-pending message delivered later by a set or on command;
- a rejected source coming back on the next resend but not the one after;
- out-of-range notices that leave a sent flag untouched;
- lowest-index-first ordering.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_OFF = 2'd1,
    OP_ON  = 2'd2,
    OP_BAD = 2'd3
  } isc_op_e;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
    logic queued;
  } isc_flags_t;
endpackage

// File: rtl/isc_num_decode.sv
module isc_num_decode #(
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 16,
  parameter int NUM_W    = 12
) (
  input  logic               valid,
  input  logic [NUM_W-1:0]   num,
  output logic [NUM_SRC-1:0] hit,
  output logic               in_range
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    localparam logic [NUM_W-1:0] MY_NUM = NUM_W'(SRC_BASE + i);
    assign hit[i] = valid && (num == MY_NUM);
  end
  assign in_range = |hit;
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any    = |req;
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/isc_slot.sv
module isc_slot
  import isc_pkg::*;
#(
  parameter int SRV_W    = 4,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              cmd_hit,
  input  isc_op_e           cmd_op,
  input  logic [SRV_W-1:0]  cmd_server,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              walk_hit,
  input  logic              take,
  output logic              queued,
  output logic [PRIO_W-1:0] prio,
  output logic [SRV_W-1:0]  server
);
  isc_flags_t        flags_q, flags_n;
  logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic              chk;

  always_comb begin
    flags_n = flags_q;
    prio_n  = prio_q;
    saved_n = saved_q;
    srv_n   = srv_q;
    chk     = 1'b0;
    flags_n.queued = flags_q.queued & ~take;
    if (rej_hit) begin
      flags_n.rejected = 1'b1;
      flags_n.sent     = 1'b0;
    end
    if (eoi_hit && IS_LEVEL) flags_n.sent = 1'b0;
    if (IS_LEVEL) begin
      if (line != flags_n.asserted) begin
        flags_n.asserted = line;
        chk = 1'b1;
      end
    end else if (line) begin
      if (prio_n == PRIO_MASKED) flags_n.mpend  = 1'b1;
      else                       flags_n.queued = 1'b1;
    end
    if (cmd_hit) begin
      case (cmd_op)
        OP_SET: begin
          srv_n   = cmd_server;
          prio_n  = cmd_prio;
          saved_n = cmd_prio;
        end
        OP_OFF: begin
          saved_n = prio_n;
          prio_n  = PRIO_MASKED;
        end
        OP_ON:   prio_n = saved_n;
        default: ;
      endcase
      if (IS_LEVEL) chk = 1'b1;
      else if (flags_n.mpend && prio_n != PRIO_MASKED) begin
        flags_n.mpend  = 1'b0;
        flags_n.queued = 1'b1;
      end
    end
    if (walk_hit) begin
      if (IS_LEVEL) chk = 1'b1;
      else if (flags_n.rejected) begin
        flags_n.rejected = 1'b0;
        if (prio_n != PRIO_MASKED) flags_n.queued = 1'b1;
      end
    end
    if (chk && IS_LEVEL && prio_n != PRIO_MASKED && flags_n.asserted && !flags_n.sent) begin
      flags_n.sent   = 1'b1;
      flags_n.queued = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
      srv_q   <= '0;
    end else begin
      flags_q <= flags_n;
      prio_q  <= prio_n;
      saved_q <= saved_n;
      srv_q   <= srv_n;
    end
  end

  assign queued = flags_q.queued;
  assign prio   = prio_q;
  assign server = srv_q;

  // R3: a masked message firing leaves a masked-pending mark
  assert_masked_pend_R3: assert property (@(posedge clk) disable iff (rst)
    (!IS_LEVEL && line && prio_q == PRIO_MASKED && !cmd_hit) |=> flags_q.mpend);

  // R6: a sent level source stays sent until reject or end-of-interrupt
  assert_sent_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (IS_LEVEL && flags_q.sent && !rej_hit && !eoi_hit) |=> flags_q.sent);

  // R5: a reject clears sent and sets rejected when nothing else acts
  assert_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (rej_hit && !cmd_hit && !walk_hit && line == flags_q.asserted)
      |=> (!flags_q.sent && flags_q.rejected));
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 16,
  parameter int NUM_W    = 12,
  parameter int SRV_W    = 4,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP =
    NUM_SRC'(((64'd1 << NUM_SRC) - 64'd1) ^ ((64'd1 << (NUM_SRC / 2)) - 64'd1))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [NUM_W-1:0]   cmd_num,
  input  logic [SRV_W-1:0]   cmd_server,
  input  logic [8:0]         cmd_prio,
  output logic               cmd_ack,
  output logic               cmd_err,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               resend_busy,
  output logic               dlv_valid,
  output logic [NUM_W-1:0]   dlv_num,
  output logic [7:0]         dlv_prio,
  output logic [SRV_W-1:0]   dlv_server,
  input  logic               dlv_ready
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_W-1:0] BASE_V = NUM_W'(SRC_BASE);
  localparam logic [NUM_W-1:0] END_V  = NUM_W'(SRC_BASE + NUM_SRC);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  isc_op_e            op;
  logic [NUM_SRC-1:0] cmd_sel, cmd_hit, rej_hit, eoi_hit, walk_hit;
  logic               cmd_in_range, rej_in_range, eoi_in_range, cmd_ok;
  logic [NUM_SRC-1:0] q_vec, take;
  logic [PRIO_W-1:0]  slot_prio [NUM_SRC];
  logic [SRV_W-1:0]   slot_srv  [NUM_SRC];
  logic               pick_any, load;
  logic [IDX_W-1:0]   pick_idx, walk_idx;
  logic [NUM_SRC-1:0] pick_oh;

  assign op = isc_op_e'(cmd_op);

  isc_num_decode #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_W(NUM_W)) u_cmd_dec (
    .valid(cmd_valid), .num(cmd_num), .hit(cmd_sel), .in_range(cmd_in_range));
  isc_num_decode #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_W(NUM_W)) u_rej_dec (
    .valid(rej_valid), .num(rej_num), .hit(rej_hit), .in_range(rej_in_range));
  isc_num_decode #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_W(NUM_W)) u_eoi_dec (
    .valid(eoi_valid), .num(eoi_num), .hit(eoi_hit), .in_range(eoi_in_range));

  assign cmd_ok  = cmd_valid && cmd_in_range && (op != OP_BAD) &&
                   !(op == OP_SET && cmd_prio[8]);
  assign cmd_hit = cmd_ok ? cmd_sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ack <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_ack <= cmd_valid;
      cmd_err <= cmd_valid && !cmd_ok;
    end
  end

  // resend walk: one source per ready clock
  assign walk_hit = (resend_busy && dlv_ready) ? (NUM_SRC'(1) << walk_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      resend_busy <= 1'b0;
      walk_idx    <= '0;
    end else if (resend_req) begin
      resend_busy <= 1'b1;
      walk_idx    <= '0;
    end else if (resend_busy && dlv_ready) begin
      if (walk_idx == LAST_IDX) resend_busy <= 1'b0;
      else                      walk_idx    <= walk_idx + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    isc_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MAP[i])) u_slot (
      .clk        (clk),
      .rst        (rst),
      .line       (src_line[i]),
      .cmd_hit    (cmd_hit[i]),
      .cmd_op     (op),
      .cmd_server (cmd_server),
      .cmd_prio   (cmd_prio[7:0]),
      .rej_hit    (rej_hit[i]),
      .eoi_hit    (eoi_hit[i]),
      .walk_hit   (walk_hit[i]),
      .take       (take[i]),
      .queued     (q_vec[i]),
      .prio       (slot_prio[i]),
      .server     (slot_srv[i])
    );
  end

  isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req(q_vec), .any(pick_any), .idx(pick_idx), .onehot(pick_oh));

  assign load = (!dlv_valid || dlv_ready) && pick_any;
  assign take = load ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_num    <= '0;
      dlv_prio   <= '0;
      dlv_server <= '0;
    end else if (load) begin
      dlv_valid  <= 1'b1;
      dlv_num    <= BASE_V + NUM_W'(pick_idx);
      dlv_prio   <= slot_prio[pick_idx];
      dlv_server <= slot_srv[pick_idx];
    end else if (dlv_ready) begin
      dlv_valid  <= 1'b0;
    end
  end

  // R1: nothing is offered in the clock after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dlv_valid && !resend_busy && !cmd_ack));

  // R2: delivered numbers lie inside the source range
  assert_num_range_R2: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_num >= BASE_V && dlv_num < END_V));

  // R10: back-pressure holds the slot
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_num) &&
                                   $stable(dlv_prio) && $stable(dlv_server)));

  // R11: the walk stands still while not ready
  assert_walk_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (resend_busy && !dlv_ready && !resend_req) |=> (resend_busy && $stable(walk_idx)));

  // R9: an invalid opcode is always refused
  assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_BAD) |=> (cmd_ack && cmd_err));
endmodule

// File: tb/irq_source_ctrl_tb.sv
module irq_source_ctrl_tb;
  localparam int NUM_SRC = 8;
  localparam int BASE    = 16;
  localparam int NUM_W   = 12;
  localparam int SRV_W   = 4;

  logic clk = 0;
  logic rst = 1;
  logic [NUM_SRC-1:0] src_line = '0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [NUM_W-1:0] cmd_num = 0;
  logic [SRV_W-1:0] cmd_server = 0;
  logic [8:0] cmd_prio = 0;
  logic cmd_ack, cmd_err;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0, dlv_ready = 1;
  logic [NUM_W-1:0] rej_num = 0, eoi_num = 0;
  logic resend_busy, dlv_valid;
  logic [NUM_W-1:0] dlv_num;
  logic [7:0] dlv_prio;
  logic [SRV_W-1:0] dlv_server;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_source_ctrl u_dut (
    .clk(clk), .rst(rst), .src_line(src_line),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_server(cmd_server), .cmd_prio(cmd_prio),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .resend_busy(resend_busy),
    .dlv_valid(dlv_valid), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
    .dlv_server(dlv_server), .dlv_ready(dlv_ready));

  function automatic int pack(int num, int prio, int srv);
    return (num << 16) | (prio << 8) | srv;
  endfunction

  // reference: every accepted delivery must match the next expected one
  always @(negedge clk) begin
    if (!rst && !done && dlv_valid && dlv_ready) begin
      int got;
      got = pack(int'(dlv_num), int'(dlv_prio), int'(dlv_server));
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected delivery actual=%h expected none", cur_req, got);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got != e) begin
          fails++;
          $display("FAIL %s delivery actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_dlv(int num, int prio, int srv, string tag);
    exp_q.push_back(pack(num, prio, srv));
    tag_q.push_back(tag);
  endtask

  task automatic settle(int n, string tag);
    repeat (n) tick();
    check_val({tag, " pending expected deliveries"}, exp_q.size(), 0);
  endtask

  task automatic do_cmd(int op, int num, int srv, int prio, int exp_err, string tag);
    tick();
    cmd_valid = 1; cmd_op = 2'(op); cmd_num = NUM_W'(num);
    cmd_server = SRV_W'(srv); cmd_prio = 9'(prio);
    tick();
    cmd_valid = 0;
    @(negedge clk);
    check_val({tag, " cmd_ack"}, int'(cmd_ack), 1);
    check_val({tag, " cmd_err"}, int'(cmd_err), exp_err);
  endtask

  task automatic fire(int idx);
    tick();
    src_line[idx] = 1;
    tick();
    src_line[idx] = 0;
  endtask

  task automatic notice(bit is_rej, int num);
    tick();
    if (is_rej) begin rej_valid = 1; rej_num = NUM_W'(num); end
    else        begin eoi_valid = 1; eoi_num = NUM_W'(num); end
    tick();
    rej_valid = 0; eoi_valid = 0;
  endtask

  task automatic resend();
    tick();
    resend_req = 1;
    tick();
    resend_req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check_val("R1 dlv_valid after reset", int'(dlv_valid), 0);
    check_val("R1 cmd_ack after reset", int'(cmd_ack), 0);
    check_val("R1 resend_busy after reset", int'(resend_busy), 0);

    // R3: masked at reset, firing is held as masked-pending
    cur_req = "R3";
    fire(0);
    settle(6, "R3 masked fire");
    expect_dlv(BASE, 5, 3, "R3 unmask delivers pending");
    do_cmd(0, BASE, 3, 5, 0, "R3");
    settle(6, "R3 after set");

    // R2: unmasked message firing
    cur_req = "R2";
    expect_dlv(BASE, 5, 3, "R2 message delivery");
    fire(0);
    settle(6, "R2");

    // R4: level source 4
    cur_req = "R4";
    do_cmd(0, BASE + 4, 2, 7, 0, "R8 set with line low");
    settle(4, "R8 no delivery when deasserted");
    expect_dlv(BASE + 4, 7, 2, "R4 level rise");
    tick(); src_line[4] = 1;
    settle(12, "R4 held line no repeat");

    // R6: EOI alone does not redeliver; resend does
    cur_req = "R6";
    notice(0, BASE + 4);
    settle(6, "R6 eoi alone");
    cur_req = "R5";
    expect_dlv(BASE + 4, 7, 2, "R5 resend after eoi level");
    resend();
    settle(14, "R5 resend level");

    // R5: reject of level source
    cur_req = "R5";
    notice(1, BASE + 4);
    settle(6, "R5 reject no immediate delivery");
    expect_dlv(BASE + 4, 7, 2, "R5 resend after reject level");
    resend();
    settle(14, "R5 level redelivered");
    tick(); src_line[4] = 0;
    notice(0, BASE + 4);
    settle(4, "R4 line drop");

    // R5: reject of message source, one redelivery only
    notice(1, BASE);
    settle(4, "R5 message reject");
    expect_dlv(BASE, 5, 3, "R5 resend message");
    resend();
    settle(14, "R5 message redelivered");
    resend();
    settle(14, "R5 second resend empty");

    // R6: EOI on message has no effect
    cur_req = "R6";
    notice(0, BASE);
    settle(6, "R6 message eoi");

    // R7: off / on
    cur_req = "R7";
    do_cmd(1, BASE, 0, 0, 0, "R7 off");
    fire(0);
    settle(6, "R7 fire while off");
    expect_dlv(BASE, 5, 3, "R7 on restores priority and server");
    do_cmd(2, BASE, 0, 0, 0, "R7 on");
    settle(6, "R7 after on");

    // R9: refused commands
    cur_req = "R9";
    do_cmd(0, BASE - 1, 1, 1, 1, "R9 number below range");
    do_cmd(0, BASE + NUM_SRC, 1, 1, 1, "R9 number above range");
    do_cmd(0, BASE, 1, 256, 1, "R9 priority above 0xFF");
    do_cmd(3, BASE, 1, 1, 1, "R9 invalid opcode");
    expect_dlv(BASE, 5, 3, "R9 state unchanged after refusals");
    fire(0);
    settle(6, "R9");

    // R10: ordering and hold
    cur_req = "R10";
    do_cmd(0, BASE + 1, 1, 9, 0, "R10 cfg1");
    do_cmd(0, BASE + 2, 0, 4, 0, "R10 cfg2");
    tick();
    dlv_ready = 0;
    src_line[1] = 1; src_line[2] = 1;
    tick();
    src_line[1] = 0; src_line[2] = 0;
    repeat (3) tick();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_val("R10 valid held", int'(dlv_valid), 1);
      check_val("R10 lowest index first held", int'(dlv_num), BASE + 1);
      tick();
    end
    expect_dlv(BASE + 1, 9, 1, "R10 first");
    expect_dlv(BASE + 2, 4, 0, "R10 second");
    dlv_ready = 1;
    settle(6, "R10");

    // R11: walk stalls and counts
    cur_req = "R11";
    tick();
    dlv_ready = 0;
    resend();
    repeat (20) tick();
    @(negedge clk);
    check_val("R11 busy while stalled", int'(resend_busy), 1);
    tick();
    dlv_ready = 1;
    begin
      int cnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (resend_busy) cnt++;
      end
      check_val("R11 ready clocks while busy", cnt, NUM_SRC);
    end
    settle(2, "R11");

    // R12: out-of-range notices ignored
    cur_req = "R12";
    expect_dlv(BASE + 4, 7, 2, "R12 setup level rise");
    tick(); src_line[4] = 1;
    settle(6, "R12 setup");
    notice(0, BASE + 20);
    resend();
    settle(14, "R12 out-of-range eoi left sent flag");
    notice(1, BASE + 30);
    resend();
    settle(14, "R12 out-of-range reject ignored");
    notice(0, BASE + 4);
    expect_dlv(BASE + 4, 7, 2, "R12 in-range eoi then resend");
    resend();
    settle(14, "R12 final");

    // R8: set command runs the level check
    cur_req = "R8";
    tick(); src_line[5] = 1;
    settle(6, "R8 masked level");
    expect_dlv(BASE + 5, 3, 1, "R8 set delivers asserted level");
    do_cmd(0, BASE + 5, 1, 3, 0, "R8");
    settle(6, "R8 after set");

    finish_run();
  end
endmodule